// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch with Direction-Based Prediction

This block is the front end of a small 16-bit processor whose memory port is only one byte wide. It keeps the program counter and fetches each 16-bit instruction as two bytes on two separate transfers. Once both bytes are in, it assembles the word and chooses the next fetch address at once. It uses a fixed rule: unconditional relative jumps are followed, backward conditional branches are followed, and everything else falls through to the next instruction.

Assembled instructions are placed in a one-entry output slot together with their byte address and the guess that was made for them. The execute stage consumes the slot whenever it is not stalling. When it finds that a guess was wrong, it sends a redirect, which discards the slot and any half-built instruction and restarts fetch at the supplied address. The program counter is held in halfword units, so every instruction address is even and relative offsets are counted in halfwords.

Top module: `ifetch_byte`

## Requirements
- R1: On synchronous reset `ins_valid` goes low and the first byte request is for address 0x0000. No instruction is presented until both of its bytes have been accepted.
- R2: Each instruction is read low byte first from its even address, then high byte from that address plus one. It is presented as `ins_word = {high, low}` with `ins_pc` equal to the even address.
- R3: A byte is accepted only in a cycle where `mem_req` and `mem_rdy` are both high. While a request waits for `mem_rdy`, `mem_addr` holds its value.
- R4: An instruction whose class field `ins_word[15:13]` is 3'b100 through 3'b111 is not a control transfer. Fetch continues at `ins_pc + 2` and `ins_pred` is 0.
- R5: Class 3'b000 (jump) and class 3'b001 (jump-and-link) are always predicted taken. Fetch continues at `ins_pc + 2*sext(ins_word[8:0])`, modulo 2^16.
- R6: Class 3'b010 (branch if zero) and class 3'b011 (branch if nonzero) with offset bit `ins_word[8]` set (a negative offset) are predicted taken to the same relative target as R5.
- R7: Class 3'b010 and class 3'b011 with `ins_word[8]` clear (an offset of zero or more) are predicted not taken, and fetch continues at `ins_pc + 2`.
- R8: `ins_pred` is 1 exactly when the next fetch after that instruction was steered to its relative target.
- R9: In a cycle with `redir_valid` high, `mem_req` is low, and in the next cycle `ins_valid` is low. Fetch resumes at `{redir_pc[15:1], 1'b0}`; bit 0 of `redir_pc` is ignored and any half-built instruction is dropped.
- R10: While `ins_valid` and `stall` are both high, the output slot holds its word, PC and guess. The low byte of the next instruction may still be fetched, but no high-byte request is made.
- R11: With `mem_rdy` held high and no stall or redirect, one instruction is presented every two cycles, including across taken jumps and branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Byte read request valid |
| mem_rdy | input | 1 | Memory accepts the request; `mem_rdata` is valid in the same cycle |
| mem_addr | output | 16 | Byte address of the request |
| mem_rdata | input | 8 | Read data byte |
| ins_valid | output | 1 | Output slot holds an instruction |
| ins_word | output | 16 | Assembled instruction |
| ins_pc | output | 16 | Byte address of the instruction (always even) |
| ins_pred | output | 1 | Fetch followed this instruction's relative target |
| stall | input | 1 | Execute stage cannot take the slot this cycle |
| redir_valid | input | 1 | Restart fetch at `redir_pc` |
| redir_pc | input | 16 | Redirect byte address; bit 0 is ignored |

## Verification
A short directed loop runs with the bus always ready and no stall. It passes through a sequential instruction, a forward branch, a forward jump, a backward branch and a backward jump-and-link. This separates taken from not-taken guesses by sign and by class, and it shows whether a taken guess costs a bubble. A directed redirect to an odd address checks that the low address bit is dropped. A long random run then mixes bus wait states, stalls and redirects to arbitrary targets, including targets where the relative adder wraps at the ends of the address space. Every presented instruction is compared with a bench model of the expected fetch stream, which shows whether assembly order, the hold behaviour under wait and stall, and flush are correct.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int BUS_W  = 8;
  localparam int INSN_W = 2 * BUS_W;
  localparam int ADDR_W = 16;
  localparam int HPC_W  = ADDR_W - 1;
  localparam int OFF_W  = 9;
  localparam int CLS_W  = 3;
  localparam int EXT_W  = ADDR_W - OFF_W - 1;

  localparam logic [CLS_W-1:0] CLS_JMP = 3'b000;
  localparam logic [CLS_W-1:0] CLS_JAL = 3'b001;
  localparam logic [CLS_W-1:0] CLS_BEZ = 3'b010;
  localparam logic [CLS_W-1:0] CLS_BNZ = 3'b011;

  typedef logic [INSN_W-1:0] insn_t;
  typedef logic [HPC_W-1:0]  hpc_t;
  typedef logic [BUS_W-1:0]  byte_t;

  typedef struct packed {
    insn_t word;
    hpc_t  hpc;
    logic  pred;
  } slot_t;

  function automatic logic [CLS_W-1:0] insn_class(insn_t w);
    return w[INSN_W-1 -: CLS_W];
  endfunction

  function automatic logic is_uncond(insn_t w);
    return (insn_class(w) == CLS_JMP) || (insn_class(w) == CLS_JAL);
  endfunction

  function automatic logic is_cond(insn_t w);
    return (insn_class(w) == CLS_BEZ) || (insn_class(w) == CLS_BNZ);
  endfunction

  // backward conditional branches and all relative jumps are followed
  function automatic logic guess_taken(insn_t w);
    return is_uncond(w) || (is_cond(w) && w[OFF_W-1]);
  endfunction

  // halfword offset expressed as a signed byte displacement
  function automatic logic [ADDR_W-1:0] byte_disp(insn_t w);
    return {{EXT_W{w[OFF_W-1]}}, w[OFF_W-1:0], 1'b0};
  endfunction
endpackage

// File: rtl/ifu_predict.sv
module ifu_predict
  import ifu_pkg::*;
(
  input  insn_t word,
  input  hpc_t  hpc,
  output hpc_t  next_hpc,
  output logic  taken
);
  logic [ADDR_W-1:0] here_b;
  logic [ADDR_W-1:0] tgt_b;
  hpc_t              seq_hpc;

  always_comb begin
    here_b   = {hpc, 1'b0};
    tgt_b    = here_b + byte_disp(word);
    seq_hpc  = hpc + hpc_t'(1);
    taken    = guess_taken(word);
    next_hpc = taken ? tgt_b[ADDR_W-1:1] : seq_hpc;
  end
endmodule

// File: rtl/ifu_seq.sv
module ifu_seq
  import ifu_pkg::*;
#(
  parameter hpc_t RESET_HPC = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  flush,
  input  hpc_t  flush_hpc,
  input  hpc_t  pred_hpc,
  input  byte_t byte_in,
  output hpc_t  hpc,
  output logic  phase,
  output byte_t lo_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hpc     <= RESET_HPC;
      phase   <= 1'b0;
      lo_byte <= '0;
    end else if (flush) begin
      hpc   <= flush_hpc;
      phase <= 1'b0;
    end else if (take) begin
      if (!phase) begin
        lo_byte <= byte_in;
        phase   <= 1'b1;
      end else begin
        phase <= 1'b0;
        hpc   <= pred_hpc;
      end
    end
  end
endmodule

// File: rtl/ifu_slot.sv
module ifu_slot
  import ifu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  load,
  input  logic  drain,
  input  slot_t din,
  output logic  valid,
  output slot_t dout
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (load && !flush) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/ifetch_byte.sv
module ifetch_byte
  import ifu_pkg::*;
#(
  parameter logic [15:0] RESET_ADDR = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic        mem_req,
  input  logic        mem_rdy,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        ins_valid,
  output logic [15:0] ins_word,
  output logic [15:0] ins_pc,
  output logic        ins_pred,
  input  logic        stall,
  input  logic        redir_valid,
  input  logic [15:0] redir_pc
);
  localparam hpc_t RESET_HPC = RESET_ADDR[ADDR_W-1:1];

  hpc_t  cur_hpc;
  hpc_t  next_hpc;
  logic  fetch_phase;
  byte_t lo_byte;
  insn_t word_now;
  logic  guess;
  logic  slot_free;
  logic  byte_take;
  logic  word_done;
  slot_t slot_in;
  slot_t slot_out;

  assign slot_free = !ins_valid || !stall;
  assign mem_req   = !rst && !redir_valid && (!fetch_phase || slot_free);
  assign mem_addr  = {cur_hpc, fetch_phase};
  assign byte_take = mem_req && mem_rdy;
  assign word_done = byte_take && fetch_phase;
  assign word_now  = {mem_rdata, lo_byte};

  ifu_predict u_pred (
    .word     (word_now),
    .hpc      (cur_hpc),
    .next_hpc (next_hpc),
    .taken    (guess)
  );

  ifu_seq #(.RESET_HPC(RESET_HPC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .take      (byte_take),
    .flush     (redir_valid),
    .flush_hpc (redir_pc[ADDR_W-1:1]),
    .pred_hpc  (next_hpc),
    .byte_in   (mem_rdata),
    .hpc       (cur_hpc),
    .phase     (fetch_phase),
    .lo_byte   (lo_byte)
  );

  assign slot_in = '{word: word_now, hpc: cur_hpc, pred: guess};

  ifu_slot u_slot (
    .clk   (clk),
    .rst   (rst),
    .flush (redir_valid),
    .load  (word_done),
    .drain (!stall),
    .din   (slot_in),
    .valid (ins_valid),
    .dout  (slot_out)
  );

  assign ins_word = slot_out.word;
  assign ins_pc   = {slot_out.hpc, 1'b0};
  assign ins_pred = slot_out.pred;
endmodule

// File: rtl/ifu_checker.sv
module ifu_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_rdy,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_rdata,
  input logic        ins_valid,
  input logic [15:0] ins_word,
  input logic [15:0] ins_pc,
  input logic        ins_pred,
  input logic        stall,
  input logic        redir_valid,
  input logic [15:0] redir_pc,
  input logic        byte_take,
  input logic        word_done
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !ins_valid);
  p_reset_addr_r1: assert property (@(posedge clk) rst |=> mem_addr == 16'h0000);

  p_byte_order_r2: assert property (@(posedge clk) disable iff (rst)
    byte_take && !mem_addr[0] |=> mem_addr == $past(mem_addr) + 16'd1);
  p_even_pc_r2: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> !ins_pc[0]);

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy && !redir_valid |=> $stable(mem_addr));

  p_seq_next_r4: assert property (@(posedge clk) disable iff (rst)
    word_done && mem_rdata[7] |=> mem_addr == $past(mem_addr) + 16'd1);

  p_jump_taken_r5: assert property (@(posedge clk) disable iff (rst)
    word_done && mem_rdata[7:6] == 2'b00 |=> ins_pred);

  p_branch_sign_r6: assert property (@(posedge clk) disable iff (rst)
    word_done && mem_rdata[7:6] == 2'b01 |=> ins_pred == ins_word[8]);

  p_redir_noreq_r9: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> !mem_req);
  p_redir_flush_r9: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !ins_valid);
  p_redir_addr_r9: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> mem_addr == {$past(redir_pc[15:1]), 1'b0});

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ins_valid && stall && !redir_valid |=>
      ins_valid && $stable(ins_word) && $stable(ins_pc) && $stable(ins_pred));
  p_stall_block_r10: assert property (@(posedge clk) disable iff (rst)
    ins_valid && stall && mem_addr[0] |-> !mem_req);
endmodule

bind ifetch_byte ifu_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_req     (mem_req),
  .mem_rdy     (mem_rdy),
  .mem_addr    (mem_addr),
  .mem_rdata   (mem_rdata),
  .ins_valid   (ins_valid),
  .ins_word    (ins_word),
  .ins_pc      (ins_pc),
  .ins_pred    (ins_pred),
  .stall       (stall),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .byte_take   (byte_take),
  .word_done   (word_done)
);

// File: tb/tb_ifetch_byte.sv
module tb_ifetch_byte;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req;
  logic        mem_rdy = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        ins_valid;
  logic [15:0] ins_word;
  logic [15:0] ins_pc;
  logic        ins_pred;
  logic        stall = 1'b0;
  logic        redir_valid = 1'b0;
  logic [15:0] redir_pc = '0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] dmem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_byte dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rdy(mem_rdy),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ins_valid(ins_valid),
    .ins_word(ins_word), .ins_pc(ins_pc), .ins_pred(ins_pred),
    .stall(stall), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  function automatic logic [15:0] mword(logic [14:0] h);
    logic [31:0] x;
    if (h[14:6] == 9'd0) return dmem[h[5:0]];
    x = {17'd0, h} * 32'h9E3779B1;
    x = x ^ (x >> 15);
    return x[15:0] ^ 16'h5A3C;
  endfunction

  always_comb mem_rdata = mem_addr[0] ? mword(mem_addr[15:1])[15:8]
                                      : mword(mem_addr[15:1])[7:0];

  function automatic logic exp_taken(logic [15:0] w);
    int cls;
    cls = int'(w >> 13);
    if (cls < 2) return 1'b1;
    if (cls < 4) return w[8];
    return 1'b0;
  endfunction

  function automatic logic [14:0] exp_next(logic [14:0] h, logic [15:0] w);
    int off;
    int r;
    off = w[8] ? int'(w[8:0]) - 512 : int'(w[8:0]);
    r = exp_taken(w) ? int'(h) + off : int'(h) + 1;
    return 15'(r & 32'h7FFF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [14:0] exp_h;
  bit          hold_pend, order_pend, redir_pend, stall_pend, free_prev;
  logic [15:0] hold_addr, order_addr, redir_addr, st_word, st_pc;
  logic        st_pred;
  int          cyc = 0, last_cons = 0;

  task automatic cycle(input logic rdy, input logic st, input logic rv,
                       input logic [15:0] rpc, input bit free);
    @(negedge clk);
    mem_rdy = rdy; stall = st; redir_valid = rv; redir_pc = rpc;
    #1;
    cyc++;
    if (hold_pend) check(mem_addr == hold_addr, "R3 wait hold", mem_addr, hold_addr);
    if (order_pend) check(mem_addr == order_addr, "R2 high byte follows", mem_addr, order_addr);
    if (redir_pend) begin
      check(!ins_valid, "R9 flush", ins_valid, 0);
      check(mem_addr == redir_addr, "R9 restart address", mem_addr, redir_addr);
    end
    if (stall_pend) begin
      check(ins_valid && ins_word == st_word && ins_pc == st_pc && ins_pred == st_pred,
            "R10 stall hold", {ins_word, ins_pc}, {st_word, st_pc});
    end
    hold_pend = 0; order_pend = 0; redir_pend = 0; stall_pend = 0;
    if (rv) check(!mem_req, "R9 no request", mem_req, 0);
    if (ins_valid && st && mem_addr[0]) check(!mem_req, "R10 high byte blocked", mem_req, 0);
    if (mem_req && !rdy && !rv) begin hold_pend = 1; hold_addr = mem_addr; end
    if (mem_req && rdy && !mem_addr[0]) begin order_pend = 1; order_addr = mem_addr + 16'd1; end
    if (ins_valid && st && !rv) begin
      stall_pend = 1; st_word = ins_word; st_pc = ins_pc; st_pred = ins_pred;
    end
    if (ins_valid && !st && !rv) begin
      logic [15:0] w;
      string tag;
      w = mword(exp_h);
      if (w[15]) tag = "R4 sequential";
      else if (!w[14]) tag = "R5 jump";
      else if (w[8]) tag = "R6 backward branch";
      else tag = "R7 forward branch";
      check(ins_pc == {exp_h, 1'b0}, {"R2 pc ", tag}, ins_pc, {exp_h, 1'b0});
      check(ins_word == w, {"R2 word ", tag}, ins_word, w);
      check(ins_pred == exp_taken(w), {"R8 guess ", tag}, ins_pred, exp_taken(w));
      if (free && free_prev)
        check(cyc - last_cons == 2, "R11 two-cycle rate", cyc - last_cons, 2);
      free_prev = free;
      last_cons = cyc;
      exp_h = exp_next(exp_h, w);
    end
    if (rv) begin
      exp_h = rpc[15:1];
      redir_pend = 1;
      redir_addr = {rpc[15:1], 1'b0};
      free_prev = 0;
    end
    if (!free) free_prev = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 16'h8000 + 16'(i * 37);
    dmem[0]  = 16'h8001;
    dmem[1]  = 16'h4005;
    dmem[2]  = 16'h000A;
    dmem[12] = 16'h61FC;
    dmem[8]  = 16'h21F8;
    void'($urandom(32'd7));
    hold_pend = 0; order_pend = 0; redir_pend = 0; stall_pend = 0; free_prev = 0;
    exp_h = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!ins_valid, "R1 no output after reset", ins_valid, 0);
    check(mem_addr == 16'h0000, "R1 first address", mem_addr, 0);
    check(mem_req, "R1 request after reset", mem_req, 1);
    cycle(1'b1, 1'b0, 1'b0, 16'h0, 1'b0);
    check(!ins_valid, "R1 nothing after one byte", ins_valid, 0);
    // directed loop: sequential, forward branch, forward jump, backward branch, backward link
    for (int i = 0; i < 60; i++) cycle(1'b1, 1'b0, 1'b0, 16'h0, 1'b1);
    // odd redirect address: bit 0 dropped
    cycle(1'b1, 1'b0, 1'b1, 16'h0011, 1'b0);
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, 1'b0, 16'h0, 1'b1);
    // stall held long, with the bus ready
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b1, 1'b0, 16'h0, 1'b0);
    // redirect near the top of the address space: relative targets may wrap
    cycle(1'b1, 1'b0, 1'b1, 16'hFFF8, 1'b0);
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0, 1'b0, 16'h0, 1'b0);
    // constrained random mix
    for (int i = 0; i < 20000; i++) begin
      logic r, s, v;
      r = ($urandom % 4) != 0;
      s = ($urandom % 5) == 0;
      v = ($urandom % 40) == 0;
      cycle(r, s, v, 16'($urandom), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule